// File: doc/BRIEF.md
# UART Baud Clock Generator

This block turns the main system clock into the bit-rate timing pulse used by an asynchronous serial transmitter and receiver. It works in two stages. A prescaler first forms a base-rate enable, either from a tap of a free-running power-of-two counter on the main clock or from the rising edges of an external clock pin. A programmable counter then divides that base rate by an 8-bit value and emits a single-cycle tick at the final rate.

Two 8-bit registers on a small bus configure the block: a source select and a divisor. The serial channel's enable input gates the whole chain. While the channel is off, both counters are held cleared and no ticks come out. The source select can only be rewritten while the channel is off. A parameter removes the external-pin option for channels that lack it.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset, both registers read 0x00 and `baudTick` is low.
- R2: Address 0 is the select register. Only bits [3:0] are stored and bits [7:4] read as zero. Address 1 is the divisor register, and all 8 bits are stored. `busRdata` shows the addressed register combinationally.
- R3: A write to the select register is ignored while `uartEn` is high, so the old code still reads back. A write to the divisor register takes effect whatever the state of `uartEn`.
- R4: Select codes 0 to 10 give one base enable every 2^code main-clock cycles.
- R5: With divisor N from 1 to 255, a tick is emitted once every N base enables, so the tick period is N·2^code cycles. Divisor 0 acts as 256.
- R6: Select code 11 on a channel built with the external pin gives one base enable per rising edge of `extClk`, sampled through a two-stage synchronizer. The tick period is therefore N rising edges of `extClk`.
- R7: Select codes 12 to 15 produce no ticks. Code 11 produces no ticks on a channel built without the external pin.
- R8: While `uartEn` is low, no tick is produced and both counters are cleared. After `uartEn` rises with a tap code, the first tick is high after the (N·2^code)-th rising clock edge. The count starts at 1 on the first edge at which `uartEn` is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main system clock |
| rstN | input | 1 | Active-low synchronous reset |
| uartEn | input | 1 | Serial channel enable; runs the counters and locks the select register |
| busAddr | input | 1 | Register address: 0 = select, 1 = divisor |
| busWe | input | 1 | Write strobe, sampled on the rising clock edge |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data of the addressed register |
| extClk | input | 1 | External base clock, asynchronous to `clk` |
| baudTick | output | 1 | One-cycle pulse at the bit rate |

## Verification
A register write is visible on `busRdata` one edge after the write strobe is sampled. Readback is therefore checked at the next falling edge, after the address has been set. The tick is registered once behind the divisor counter, so the first tick after enable is high after exactly N·2^code edges. The bench counts rising edges from the enabling edge and samples `baudTick` at each following falling edge, which keeps it clear of the active edge. Periods are measured between successive ticks sampled on falling edges. Reserved codes and the disabled state are checked by counting ticks over windows that are longer than any legal period that could occur in them.

// File: rtl/bclk_pkg.sv
package bclk_pkg;
  localparam int unsigned SEL_W = 4;
  localparam logic ADDR_SEL = 1'b0;
  localparam logic ADDR_DIV = 1'b1;

  // strobes from the register/control side to the counting datapath
  typedef struct packed {
    logic             run;     // channel enabled
    logic             useTap;  // select code names a prescaler tap
    logic             useExt;  // select code names the external pin
    logic [SEL_W-1:0] tapIdx;  // tap number when useTap is set
  } baseCtl_t;
endpackage

// File: rtl/bclk_ctrl.sv
module bclk_ctrl
  import bclk_pkg::*;
#(
  parameter int unsigned REG_W   = 8,
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned PRESC_W = 10,
  parameter bit          HAS_EXT = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             uartEn,
  input  logic             busAddr,
  input  logic             busWe,
  input  logic [REG_W-1:0] busWdata,
  output logic [REG_W-1:0] busRdata,
  output baseCtl_t         ctl,
  output logic [DIV_W-1:0] divisor
);
  localparam logic [SEL_W-1:0] LAST_TAP = SEL_W'(PRESC_W);
  localparam logic [SEL_W-1:0] EXT_CODE = SEL_W'(PRESC_W + 1);

  logic [SEL_W-1:0] selCode;
  logic [DIV_W-1:0] divReg;
  logic             selWrite;
  logic             divWrite;

  assign selWrite = busWe && (busAddr == ADDR_SEL) && !uartEn;
  assign divWrite = busWe && (busAddr == ADDR_DIV);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selCode <= '0;
      divReg  <= '0;
    end else begin
      if (selWrite) selCode <= busWdata[SEL_W-1:0];
      if (divWrite) divReg  <= busWdata[DIV_W-1:0];
    end
  end

  always_comb begin
    busRdata = '0;
    if (busAddr == ADDR_SEL) busRdata[SEL_W-1:0] = selCode;
    else                     busRdata[DIV_W-1:0] = divReg;
  end

  always_comb begin
    ctl.run    = uartEn;
    ctl.useTap = (selCode <= LAST_TAP);
    ctl.useExt = HAS_EXT && (selCode == EXT_CODE);
    ctl.tapIdx = selCode;
  end

  assign divisor = divReg;

  // R3: select code frozen whenever the channel is enabled
  assert_sel_locked_R3: assert property (@(posedge clk) disable iff (!rstN)
    uartEn |=> $stable(selCode));

  // R3: divisor write accepted regardless of enable
  assert_div_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_DIV) |=> (divReg == $past(busWdata[DIV_W-1:0])));
endmodule

// File: rtl/bclk_dp.sv
module bclk_dp
  import bclk_pkg::*;
#(
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned PRESC_W     = 10,
  parameter bit          HAS_EXT     = 1'b1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  baseCtl_t         ctl,
  input  logic [DIV_W-1:0] divisor,
  input  logic             extClk,
  output logic             tick
);
  logic [PRESC_W-1:0] prescCnt;
  logic [PRESC_W:0]   tapHit;
  logic               tapSel;
  logic               extEdge;
  logic               baseEn;
  logic [DIV_W-1:0]   divCnt;
  logic [DIV_W-1:0]   lastCnt;
  logic               wrapNow;
  logic               tickQ;

  // free-running prescaler, cleared while the channel is off
  always_ff @(posedge clk) begin
    if (!rstN)         prescCnt <= '0;
    else if (!ctl.run) prescCnt <= '0;
    else               prescCnt <= prescCnt + 1'b1;
  end

  assign tapHit[0] = 1'b1;
  for (genvar k = 1; k <= PRESC_W; k++) begin : g_tap
    assign tapHit[k] = &prescCnt[k-1:0];
  end

  always_comb begin
    tapSel = 1'b0;
    for (int k = 0; k <= PRESC_W; k++) begin
      if (ctl.tapIdx == SEL_W'(k)) tapSel = tapHit[k];
    end
  end

  if (HAS_EXT) begin : g_ext
    logic [SYNC_STAGES-1:0] syncQ;
    logic                   extPrev;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        syncQ   <= '0;
        extPrev <= 1'b0;
      end else begin
        syncQ   <= {syncQ[SYNC_STAGES-2:0], extClk};
        extPrev <= syncQ[SYNC_STAGES-1];
      end
    end
    assign extEdge = syncQ[SYNC_STAGES-1] & ~extPrev;

    // R6: a detected rising edge can never repeat on the next cycle
    assert_ext_edge_single_R6: assert property (@(posedge clk) disable iff (!rstN)
      extEdge |=> !extEdge);
  end else begin : g_noext
    assign extEdge = 1'b0;
  end

  assign baseEn = ctl.run && ((ctl.useTap && tapSel) || (ctl.useExt && extEdge));

  // divide base enables by divisor (0 behaves as 2^DIV_W)
  assign lastCnt = divisor - 1'b1;
  assign wrapNow = (divCnt == lastCnt);

  always_ff @(posedge clk) begin
    if (!rstN)         divCnt <= '0;
    else if (!ctl.run) divCnt <= '0;
    else if (baseEn)   divCnt <= wrapNow ? '0 : divCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) tickQ <= 1'b0;
    else       tickQ <= baseEn && wrapNow;
  end

  assign tick = tickQ;

  // R8: counters held cleared while disabled
  assert_presc_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.run |=> (prescCnt == '0 && divCnt == '0));

  // R8: no tick follows a disabled cycle
  assert_quiet_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.run |=> !tick);

  // R7: reserved select codes stay silent
  assert_reserved_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.useTap && !ctl.useExt) |=> !tick);
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import bclk_pkg::*;
#(
  parameter int unsigned REG_W       = 8,
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned PRESC_W     = 10,
  parameter bit          HAS_EXT     = 1'b1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             uartEn,
  input  logic             busAddr,
  input  logic             busWe,
  input  logic [REG_W-1:0] busWdata,
  output logic [REG_W-1:0] busRdata,
  input  logic             extClk,
  output logic             baudTick
);
  baseCtl_t         ctl;
  logic [DIV_W-1:0] divisor;

  bclk_ctrl #(
    .REG_W(REG_W), .DIV_W(DIV_W), .PRESC_W(PRESC_W), .HAS_EXT(HAS_EXT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .uartEn(uartEn), .busAddr(busAddr),
    .busWe(busWe), .busWdata(busWdata), .busRdata(busRdata),
    .ctl(ctl), .divisor(divisor)
  );

  bclk_dp #(
    .DIV_W(DIV_W), .PRESC_W(PRESC_W), .HAS_EXT(HAS_EXT), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .divisor(divisor),
    .extClk(extClk), .tick(baudTick)
  );
endmodule

// File: tb/tb_baud_tick_gen.sv
module tb_baud_tick_gen;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rstN, uartEn, busAddr, busWe, extClk, extOn;
  logic [7:0] busWdata;
  logic [7:0] busRdata, rdNoExt;
  logic       baudTick, tickNoExt;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  baud_tick_gen dut (
    .clk(clk), .rstN(rstN), .uartEn(uartEn), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .extClk(extClk), .baudTick(baudTick)
  );

  baud_tick_gen #(.HAS_EXT(1'b0)) dutNoExt (
    .clk(clk), .rstN(rstN), .uartEn(uartEn), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(rdNoExt), .extClk(extClk), .baudTick(tickNoExt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); busAddr = a; busWe = 1'b1; busWdata = d;
    @(negedge clk); busWe = 1'b0;
  endtask

  task automatic rdChk(input logic a, input int exp, input string req);
    @(negedge clk); busAddr = a; #1;
    chk(busRdata == exp[7:0], req, int'(busRdata), exp);
  endtask

  // disable, program, then enable and find the first tick edge number
  task automatic startAndLatency(input int code, input int dv, input int exp, input string req);
    int n, first;
    @(negedge clk); uartEn = 1'b0;
    wr(1'b0, 8'(code));
    wr(1'b1, 8'(dv));
    @(negedge clk); uartEn = 1'b1;
    n = 0; first = -1;
    while (n < exp + 2) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (baudTick && first < 0) first = n;
    end
    if (exp >= 0) chk(first == exp, req, first, exp);
  endtask

  task automatic measure(input int exp, input string req);
    int w, gap;
    w = 0;
    @(negedge clk);
    while (!baudTick && w < 300000) begin @(negedge clk); w++; end
    gap = 0;
    do begin @(negedge clk); gap++; end while (!baudTick && gap < 300000);
    chk(gap == exp, req, gap, exp);
  endtask

  task automatic countTicks(input int cycles, output int t, output int t1);
    t = 0; t1 = 0;
    repeat (cycles) begin
      @(negedge clk);
      if (baudTick) t++;
      if (tickNoExt) t1++;
    end
  endtask

  initial begin
    int extPh;
    extClk = 1'b0; extPh = 0;
    forever begin
      @(negedge clk);
      if (extOn) begin
        extPh++;
        if (extPh == 3) begin extPh = 0; extClk = ~extClk; end
      end
    end
  end

  initial begin
    int t, t1;
    rstN = 1'b0; uartEn = 1'b0; busAddr = 1'b0; busWe = 1'b0; busWdata = '0; extOn = 1'b0;
    repeat (3) @(negedge clk);
    chk(baudTick == 1'b0, "R1 tick low in reset", int'(baudTick), 0);
    rstN = 1'b1;
    rdChk(1'b0, 0, "R1 select reset");
    rdChk(1'b1, 0, "R1 divisor reset");

    // R2 field widths
    wr(1'b0, 8'hF3); rdChk(1'b0, 8'h03, "R2 select upper bits zero");
    wr(1'b1, 8'hA5); rdChk(1'b1, 8'hA5, "R2 divisor full width");

    // R8 disabled: no ticks
    wr(1'b0, 8'h00); wr(1'b1, 8'h01);
    countTicks(300, t, t1);
    chk(t == 0, "R8 no tick while disabled", t, 0);

    // R3 lock while enabled
    @(negedge clk); uartEn = 1'b1;
    wr(1'b0, 8'h05); rdChk(1'b0, 0, "R3 select write ignored when enabled");
    wr(1'b1, 8'h09); rdChk(1'b1, 9, "R3 divisor write accepted when enabled");
    @(negedge clk); uartEn = 1'b0;
    wr(1'b0, 8'h05); rdChk(1'b0, 5, "R3 select write accepted when disabled");

    // R4 and R8: every tap, divisor 3, latency then period
    for (int code = 0; code <= 10; code++) begin
      startAndLatency(code, 3, 3 << code, "R8 first tick latency");
      measure(3 << code, "R4 tap period");
    end

    // R5 divisor sweep
    startAndLatency(0, 1, 1, "R5 divisor 1 latency");
    measure(1, "R5 divisor 1 period");
    startAndLatency(0, 2, 2, "R5 divisor 2 latency");
    measure(2, "R5 divisor 2 period");
    startAndLatency(0, 7, 7, "R5 divisor 7 latency");
    measure(7, "R5 divisor 7 period");
    startAndLatency(0, 255, 255, "R5 divisor 255 latency");
    measure(255, "R5 divisor 255 period");
    startAndLatency(0, 0, 256, "R5 divisor 0 as 256 latency");
    measure(256, "R5 divisor 0 as 256 period");
    startAndLatency(2, 5, 20, "R5 code 2 divisor 5 latency");
    measure(20, "R5 code 2 divisor 5 period");

    // R6 external clock: rising edge every 6 cycles, divisor 4
    extOn = 1'b1;
    startAndLatency(11, 4, -1, "R6 setup");
    measure(24, "R6 external period");
    measure(24, "R6 external period repeat");
    countTicks(240, t, t1);
    chk(t == 10, "R6 external tick count", t, 10);
    chk(t1 == 0, "R7 code 11 silent without external pin", t1, 0);
    extOn = 1'b0;

    // R7 reserved codes
    for (int code = 12; code <= 15; code++) begin
      startAndLatency(code, 1, -1, "R7 setup");
      countTicks(300, t, t1);
      chk(t == 0, "R7 reserved code silent", t, 0);
    end

    // R8 disable stops a running chain
    startAndLatency(0, 1, 1, "R8 restart latency");
    @(negedge clk); uartEn = 1'b0;
    @(negedge clk);
    countTicks(100, t, t1);
    chk(t == 0, "R8 ticks stop after disable", t, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1900000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule